// File: doc/BRIEF.md
# Clock Calendar with Alarm and Periodic Interrupts

This block keeps time of day and a two-digit-year calendar. It is driven by a 32.768 kHz reference enable, which it divides down to a one-second tick. It counts seconds, minutes, hours, day of week, day of month, month and year. Each second the update-done event fires. When the time matches a programmed alarm, the alarm event fires. A programmable divider of the reference raises a periodic event. Each of the three event flags has its own enable. The interrupt request is active whenever any enabled flag is set.

Software uses a plain register port to set the time, the alarm and the control bits. Setting the control bits selects binary or BCD presentation, 12- or 24-hour hours, and an optional daylight-saving shift. Values are held internally in binary, and they are converted at the port in the format currently selected. Reading the flag register returns the pending flags and clears them.

Top module: `rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00 (shown as 12 AM, byte 0x12, because the control byte resets to BCD and 12-hour mode). The calendar reads weekday 1, day 1, month 1, year 0. Control, rate, alarm and flag registers read 0, and irq is low.
- R2: The seconds count advances once per 2^DIV_W reference enables. Each field wraps (59 to 0) and carries into the next field.
- R3: Control bit 2 selects the presentation of written and read time values: 1 gives binary and 0 gives BCD.
- R4: Control bit 1 = 1 selects 24-hour hours (0 to 23). Control bit 1 = 0 selects 12-hour hours: values 1 to 12, with bit 7 of the hour byte set for PM, so 11 PM plus one hour reads as 12 AM.
- R5: February has 29 days when the year is a multiple of 4 and 28 days otherwise. April, June, September and November have 30 days; all other months have 31.
- R6: The weekday counts 1 to 7 and then returns to 1. Month 12 wraps to 1, and year 99 wraps to 0.
- R7: With control bit 0 set, on a Sunday (weekday 1) in April with day 7 or earlier, 01:59:59 is followed by 03:00:00.
- R8: With control bit 0 set, on a Sunday in October with day 25 or later, 01:59:59 is followed by 01:00:00 the first time only. The next pass is followed by 02:00:00.
- R9: An alarm byte of 0xC0 or above matches any value. The alarm flag (flag bit 1) is set one cycle after the second update that produced a match.
- R10: The periodic flag (flag bit 2) is set every 2^(code-1) reference enables for rate codes 3 to 15, and each second boundary is also a periodic boundary. Codes 0 to 2 never set it.
- R11: The update flag (flag bit 0) is set on the edge where the seconds advance.
- R12: irq is high exactly when a flag is set whose enable is set. Control bits 6, 5 and 4 enable the periodic, alarm and update flags.
- R13: A read of address 12 returns {irq, periodic, alarm, update, 4'b0} and clears all flags on that edge. A flag being set on the same edge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at address 12) |
| reg_addr | input | 4 | Register address: 0-6 time/calendar, 7-9 alarm s/m/h, 10 rate, 11 control, 12 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| evt_flags | output | 3 | Pending flags: [2] periodic, [1] alarm, [0] update |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest states to reach are the calendar and daylight-saving edges. They only occur at particular dates and at one second per day, so a free-running clock would need months of simulated time to get there. The bench therefore uses a 4-bit prescaler and writes the time to one second before each boundary: year end, 28/29 February, 30-day month ends, 11 PM and 11 AM in 12-hour mode, and the spring and autumn Sunday transitions. The alarm and periodic tests run with a gapped reference enable. This makes the flag edges fall on uneven cycles, and a behavioural model predicts each of them on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] dow;
    logic [6:0] dom;
    logic [6:0] mon;
    logic [6:0] year;
  } rtc_time_t;

  localparam int N_EVT = 3;

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_DOW   = 4'd3;
  localparam logic [3:0] A_DOM   = 4'd4;
  localparam logic [3:0] A_MON   = 4'd5;
  localparam logic [3:0] A_YEAR  = 4'd6;
  localparam logic [3:0] A_ASEC  = 4'd7;
  localparam logic [3:0] A_AMIN  = 4'd8;
  localparam logic [3:0] A_AHOUR = 4'd9;
  localparam logic [3:0] A_RATE  = 4'd10;
  localparam logic [3:0] A_CTRL  = 4'd11;
  localparam logic [3:0] A_FLAGS = 4'd12;

  localparam logic [7:0] ALM_ANY = 8'hC0;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin,
                                          input logic hr24);
    logic [6:0] h12;
    logic [7:0] e;
    if (hr24) return enc_field(h, bin);
    if (h == 7'd0)       h12 = 7'd12;
    else if (h > 7'd12)  h12 = h - 7'd12;
    else                 h12 = h;
    e = enc_field(h12, bin);
    return {(h >= 7'd12), e[6:0]};
  endfunction

  function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic hr24);
    logic [6:0] base;
    if (hr24) return dec_field(b, bin);
    base = dec_field({1'b0, b[6:0]}, bin);
    if (base == 7'd12) base = 7'd0;
    return b[7] ? base + 7'd12 : base;
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] mon,
                                               input logic [6:0] year);
    case (mon)
      7'd2:                      return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic [3:0] rate_code,
  output logic       sec_tick,
  output logic       per_tick
);
  localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] mask;
  logic             rate_valid;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < (int'(rate_code) - 1));
    end
  end

  assign rate_valid = (rate_code >= 4'd3);
  assign sec_tick   = ref_en && (&cnt_q);
  assign per_tick   = ref_en && rate_valid && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (ref_en) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: a whole-second boundary is always a periodic boundary
  p_sec_is_periodic_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && rate_valid) |-> per_tick);

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [6:0] wr_val,
  input  logic       dst_en,
  output rtc_time_t  now_o
);
  rtc_time_t cur_q, nxt;
  logic      fell_q, fell_d;
  logic      spring_day, autumn_day, last_sec_of_hour;
  logic [6:0] dim;

  assign spring_day = (cur_q.mon == 7'd4)  && (cur_q.dow == 7'd1) && (cur_q.dom <= 7'd7);
  assign autumn_day = (cur_q.mon == 7'd10) && (cur_q.dow == 7'd1) && (cur_q.dom >= 7'd25);
  assign last_sec_of_hour = (cur_q.sec >= 7'd59) && (cur_q.min >= 7'd59);
  assign dim = days_in_month(cur_q.mon, cur_q.year);

  always_comb begin
    nxt    = cur_q;
    fell_d = fell_q;
    if (wr_en) begin
      case (wr_sel)
        3'd0:    nxt.sec  = wr_val;
        3'd1:    nxt.min  = wr_val;
        3'd2:    nxt.hour = wr_val;
        3'd3:    nxt.dow  = wr_val;
        3'd4:    nxt.dom  = wr_val;
        3'd5:    nxt.mon  = wr_val;
        default: nxt.year = wr_val;
      endcase
    end else if (tick) begin
      if (cur_q.sec < 7'd59) begin
        nxt.sec = cur_q.sec + 7'd1;
      end else begin
        nxt.sec = 7'd0;
        if (cur_q.min < 7'd59) begin
          nxt.min = cur_q.min + 7'd1;
        end else begin
          nxt.min = 7'd0;
          if (dst_en && (cur_q.hour == 7'd1) && spring_day) begin
            nxt.hour = 7'd3;
          end else if (dst_en && (cur_q.hour == 7'd1) && autumn_day && !fell_q) begin
            nxt.hour = 7'd1;
            fell_d   = 1'b1;
          end else if (cur_q.hour < 7'd23) begin
            nxt.hour = cur_q.hour + 7'd1;
            if (cur_q.hour == 7'd1) fell_d = 1'b0;
          end else begin
            nxt.hour = 7'd0;
            nxt.dow  = (cur_q.dow >= 7'd7) ? 7'd1 : cur_q.dow + 7'd1;
            if (cur_q.dom < dim) begin
              nxt.dom = cur_q.dom + 7'd1;
            end else begin
              nxt.dom = 7'd1;
              if (cur_q.mon < 7'd12) begin
                nxt.mon = cur_q.mon + 7'd1;
              end else begin
                nxt.mon  = 7'd1;
                nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.sec  <= 7'd0;
      cur_q.min  <= 7'd0;
      cur_q.hour <= 7'd0;
      cur_q.dow  <= 7'd1;
      cur_q.dom  <= 7'd1;
      cur_q.mon  <= 7'd1;
      cur_q.year <= 7'd0;
      fell_q     <= 1'b0;
    end else begin
      cur_q  <= nxt;
      fell_q <= fell_d;
    end
  end

  assign now_o = cur_q;

  // R2: seconds step by one on a tick below 59
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && cur_q.sec < 7'd59) |=> (now_o.sec == $past(cur_q.sec) + 7'd1));

  // R5: leap-year February reaches day 29
  p_leap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && last_sec_of_hour && cur_q.hour == 7'd23 && cur_q.mon == 7'd2
     && cur_q.dom == 7'd28 && cur_q.year[1:0] == 2'b00) |=> (now_o.dom == 7'd29));

  // R6: last second of year 99 wraps to year 0
  p_year_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && last_sec_of_hour && cur_q.hour == 7'd23 && cur_q.mon == 7'd12
     && cur_q.dom == 7'd31 && cur_q.year == 7'd99) |=> (now_o.year == 7'd0));

  // R7: spring shift skips hour 2
  p_spring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && dst_en && spring_day && last_sec_of_hour && cur_q.hour == 7'd1)
    |=> (now_o.hour == 7'd3));

  // R8: after the repeat, the next pass moves on to hour 2
  p_autumn_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && dst_en && autumn_day && last_sec_of_hour && cur_q.hour == 7'd1
     && fell_q) |=> (now_o.hour == 7'd2));

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] en_i,
  input  logic             clr_i,
  output logic [N_EVT-1:0] flags_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    assign flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);

  // R13: a clearing read with nothing new leaves no flag
  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags_o == '0));

  // R13: without a clearing read, set flags stay set
  p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [2:0] evt_flags,
  output logic       irq
);
  rtc_time_t now;
  logic       sec_tick, per_tick;
  logic       time_wr, flag_clr;
  logic [6:0] wr_val;

  logic       dst_q, hr24_q, bin_q;
  logic [2:0] en_q;
  logic       dst_d, hr24_d, bin_d;
  logic [2:0] en_d;
  logic [3:0] rate_q, rate_d;
  logic [7:0] asec_q, amin_q, ahour_q;
  logic [7:0] asec_d, amin_d, ahour_d;
  logic       upd_q;
  logic       alarm_hit, upd_set, alm_set;
  logic [2:0] set_vec;

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (ref_en),
    .rate_code (rate_q),
    .sec_tick  (sec_tick),
    .per_tick  (per_tick)
  );

  assign time_wr = reg_wr && (reg_addr <= A_YEAR);
  assign wr_val  = (reg_addr == A_HOUR) ? dec_hour(reg_wdata, bin_q, hr24_q)
                                        : dec_field(reg_wdata, bin_q);

  rtc_timekeeper u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (sec_tick),
    .wr_en  (time_wr),
    .wr_sel (reg_addr[2:0]),
    .wr_val (wr_val),
    .dst_en (dst_q),
    .now_o  (now)
  );

  // control, rate and alarm registers
  always_comb begin
    dst_d   = dst_q;
    hr24_d  = hr24_q;
    bin_d   = bin_q;
    en_d    = en_q;
    rate_d  = rate_q;
    asec_d  = asec_q;
    amin_d  = amin_q;
    ahour_d = ahour_q;
    if (reg_wr) begin
      case (reg_addr)
        A_ASEC:  asec_d  = reg_wdata;
        A_AMIN:  amin_d  = reg_wdata;
        A_AHOUR: ahour_d = reg_wdata;
        A_RATE:  rate_d  = reg_wdata[3:0];
        A_CTRL: begin
          dst_d  = reg_wdata[0];
          hr24_d = reg_wdata[1];
          bin_d  = reg_wdata[2];
          en_d   = reg_wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= 1'b0;
      hr24_q  <= 1'b0;
      bin_q   <= 1'b0;
      en_q    <= 3'b000;
      rate_q  <= 4'd0;
      asec_q  <= 8'd0;
      amin_q  <= 8'd0;
      ahour_q <= 8'd0;
      upd_q   <= 1'b0;
    end else begin
      dst_q   <= dst_d;
      hr24_q  <= hr24_d;
      bin_q   <= bin_d;
      en_q    <= en_d;
      rate_q  <= rate_d;
      asec_q  <= asec_d;
      amin_q  <= amin_d;
      ahour_q <= ahour_d;
      upd_q   <= upd_set;
    end
  end

  // alarm compare in the presented format, with don't-care bytes
  assign alarm_hit = ((asec_q  >= ALM_ANY) || (asec_q  == enc_field(now.sec, bin_q))) &&
                     ((amin_q  >= ALM_ANY) || (amin_q  == enc_field(now.min, bin_q))) &&
                     ((ahour_q >= ALM_ANY) || (ahour_q == enc_hour(now.hour, bin_q, hr24_q)));

  assign upd_set  = sec_tick && !time_wr;
  assign alm_set  = upd_q && alarm_hit;
  assign set_vec  = {per_tick, alm_set, upd_set};
  assign flag_clr = reg_rd && (reg_addr == A_FLAGS);

  rtc_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .en_i    (en_q),
    .clr_i   (flag_clr),
    .flags_o (evt_flags),
    .irq_o   (irq)
  );

  always_comb begin
    case (reg_addr)
      A_SEC:   reg_rdata = enc_field(now.sec, bin_q);
      A_MIN:   reg_rdata = enc_field(now.min, bin_q);
      A_HOUR:  reg_rdata = enc_hour(now.hour, bin_q, hr24_q);
      A_DOW:   reg_rdata = enc_field(now.dow, bin_q);
      A_DOM:   reg_rdata = enc_field(now.dom, bin_q);
      A_MON:   reg_rdata = enc_field(now.mon, bin_q);
      A_YEAR:  reg_rdata = enc_field(now.year, bin_q);
      A_ASEC:  reg_rdata = asec_q;
      A_AMIN:  reg_rdata = amin_q;
      A_AHOUR: reg_rdata = ahour_q;
      A_RATE:  reg_rdata = {4'b0000, rate_q};
      A_CTRL:  reg_rdata = {1'b0, en_q, 1'b0, bin_q, hr24_q, dst_q};
      A_FLAGS: reg_rdata = {irq, evt_flags, 4'b0000};
      default: reg_rdata = 8'h00;
    endcase
  end

  // R9: an alarm flag only appears the cycle after a second update
  p_alarm_after_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[1]) |-> $past(upd_q));

  // R11: the update flag rises only on a second tick
  p_update_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[0]) |-> $past(sec_tick));

  // R12: a request implies a pending flag
  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flags != 3'b000));

endmodule

// File: tb/rtc_core_tb_top.sv
`timescale 1ns/1ps
module rtc_core_tb_top;
  localparam int MW   = 4;
  localparam int MCNT = 1 << MW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [2:0] evt_flags;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int ref_mode = 0;
  int phase = 0;
  bit done = 0;

  // behavioural reference state
  int m_sec, m_min, m_hour, m_dow, m_dom, m_mon, m_year, m_fell;
  int m_cnt, m_rate, m_as, m_am, m_ah, m_flags, m_upd;
  int m_dst, m_hr24, m_bin, m_en;

  rtc_core #(.DIV_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_flags(evt_flags), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic int menc(int v, int bin);
    return bin ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int mdec(int b, int bin);
    return bin ? (b & 127) : (((b >> 4) * 10 + (b & 15)) % 128);
  endfunction
  function automatic int mhenc(int h);
    int h12;
    if (m_hr24) return menc(h, m_bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (h >= 12 ? 128 : 0) + menc(h12, m_bin);
  endfunction
  function automatic int mhdec(int b);
    int base;
    if (m_hr24) return mdec(b, m_bin);
    base = mdec(b & 127, m_bin);
    if (base == 12) base = 0;
    return (b & 128) ? base + 12 : base;
  endfunction
  function automatic int mdim();
    if (m_mon == 2) return (m_year % 4 == 0) ? 29 : 28;
    if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
    return 31;
  endfunction
  function automatic int mirq();
    return ((m_flags & m_en) != 0) ? 1 : 0;
  endfunction
  function automatic int mread(int a);
    case (a)
      0: return menc(m_sec, m_bin);
      1: return menc(m_min, m_bin);
      2: return mhenc(m_hour);
      3: return menc(m_dow, m_bin);
      4: return menc(m_dom, m_bin);
      5: return menc(m_mon, m_bin);
      6: return menc(m_year, m_bin);
      7: return m_as;
      8: return m_am;
      9: return m_ah;
      10: return m_rate;
      11: return m_en * 16 + m_bin * 4 + m_hr24 * 2 + m_dst;
      12: return mirq() * 128 + m_flags * 16;
      default: return 0;
    endcase
  endfunction

  task automatic m_advance();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_dst && m_hour == 1 && m_mon == 4 && m_dow == 1 && m_dom <= 7) m_hour = 3;
    else if (m_dst && m_hour == 1 && m_mon == 10 && m_dow == 1 && m_dom >= 25 && !m_fell) begin
      m_hour = 1; m_fell = 1;
    end else if (m_hour < 23) begin
      if (m_hour == 1) m_fell = 0;
      m_hour++;
    end else begin
      m_hour = 0;
      m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
      if (m_dom < mdim()) m_dom++;
      else begin
        m_dom = 1;
        if (m_mon < 12) m_mon++;
        else begin m_mon = 1; m_year = (m_year >= 99) ? 0 : m_year + 1; end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_year = 0;
      m_fell = 0; m_cnt = 0; m_rate = 0; m_as = 0; m_am = 0; m_ah = 0; m_flags = 0;
      m_upd = 0; m_dst = 0; m_hr24 = 0; m_bin = 0; m_en = 0;
    end else begin
      int a, d, stick, ptick, p, msk, hit, twr, sets;
      a = reg_addr; d = reg_wdata;
      twr = (reg_wr && a <= 6) ? 1 : 0;
      stick = (ref_en && m_cnt == MCNT - 1) ? 1 : 0;
      p = m_rate - 1; if (p > MW) p = MW;
      msk = (1 << p) - 1;
      ptick = (ref_en && m_rate >= 3 && ((m_cnt & msk) == msk)) ? 1 : 0;
      hit = ((m_as >= 'hC0 || m_as == menc(m_sec, m_bin)) &&
             (m_am >= 'hC0 || m_am == menc(m_min, m_bin)) &&
             (m_ah >= 'hC0 || m_ah == mhenc(m_hour))) ? 1 : 0;
      sets = ptick * 4 + ((m_upd && hit) ? 2 : 0) + ((stick && !twr) ? 1 : 0);
      m_flags = ((reg_rd && a == 12) ? 0 : m_flags) | sets;
      m_upd = (stick && !twr) ? 1 : 0;
      if (twr) begin
        case (a)
          0: m_sec = mdec(d, m_bin);
          1: m_min = mdec(d, m_bin);
          2: m_hour = mhdec(d);
          3: m_dow = mdec(d, m_bin);
          4: m_dom = mdec(d, m_bin);
          5: m_mon = mdec(d, m_bin);
          default: m_year = mdec(d, m_bin);
        endcase
      end else if (stick) m_advance();
      if (reg_wr) begin
        case (a)
          7: m_as = d;
          8: m_am = d;
          9: m_ah = d;
          10: m_rate = d & 15;
          11: begin m_dst = d & 1; m_hr24 = (d >> 1) & 1; m_bin = (d >> 2) & 1; m_en = (d >> 4) & 7; end
          default: ;
        endcase
      end
      if (ref_en) m_cnt = (m_cnt + 1) % MCNT;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the event outputs against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(evt_flags[2] == m_flags[2], "R10 periodic flag", evt_flags[2], m_flags[2]);
      chk(evt_flags[1] == m_flags[1], "R9 alarm flag", evt_flags[1], m_flags[1]);
      chk(evt_flags[0] == m_flags[0], "R11 update flag", evt_flags[0], m_flags[0]);
      chk(irq == mirq(), "R12 irq", irq, mirq());
    end
  end

  // reference enable stimulus
  always @(negedge clk) begin
    phase++;
    if (ref_mode == 0)      ref_en = 1'b0;
    else if (ref_mode == 1) ref_en = 1'b1;
    else                    ref_en = (phase % 3 != 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(int a, string req);
    int e;
    @(negedge clk);
    reg_addr = 4'(a); reg_rd = 1'b1;
    #1 e = mread(a);
    chk(reg_rdata == 8'(e), req, reg_rdata, e);
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic settime(int y, int mo, int dd, int dw, int h, int mi, int s);
    ref_mode = 0;
    wr(6, y); wr(5, mo); wr(4, dd); wr(3, dw); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic run(int n, int mode);
    ref_mode = mode;
    repeat (n) @(negedge clk);
    ref_mode = 0;
  endtask

  task automatic readall(string req);
    for (int i = 0; i < 7; i++) rd(i, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    readall("R1 reset time");
    for (int i = 7; i < 13; i++) rd(i, "R1 reset regs");

    // R2 / R6 carries through to year wrap (BCD, 24h)
    wr(11, 'h02);
    settime('h99, 'h12, 'h31, 'h07, 'h23, 'h59, 'h58);
    run(40, 1); readall("R6 year wrap");
    settime('h05, 'h03, 'h10, 'h02, 'h08, 'h14, 'h30);
    run(50, 1); readall("R2 second count");

    // R5 month lengths
    settime('h24, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59); run(20, 1); readall("R5 leap 28");
    settime('h24, 'h02, 'h29, 'h04, 'h23, 'h59, 'h59); run(20, 1); readall("R5 leap 29");
    settime('h23, 'h02, 'h28, 'h04, 'h23, 'h59, 'h59); run(20, 1); readall("R5 common 28");
    settime('h25, 'h04, 'h30, 'h05, 'h23, 'h59, 'h59); run(20, 1); readall("R5 30-day");

    // R3 binary presentation
    wr(11, 'h06);
    settime(45, 11, 30, 4, 13, 59, 59); run(20, 1); readall("R3 binary");
    rd(11, "R3 control readback");

    // R4 12-hour mode, BCD
    wr(11, 'h00);
    settime('h10, 'h06, 'h15, 'h03, 'h91, 'h59, 'h59); run(20, 1); readall("R4 11PM wrap");
    settime('h10, 'h06, 'h15, 'h03, 'h11, 'h59, 'h59); run(20, 1); readall("R4 11AM to PM");
    settime('h10, 'h06, 'h15, 'h03, 'h12, 'h59, 'h59); run(20, 1); readall("R4 12AM to 1");

    // R7 / R8 daylight-saving shifts (24h BCD, enabled)
    wr(11, 'h03);
    settime('h26, 'h04, 'h05, 'h01, 'h01, 'h59, 'h59); run(20, 1); readall("R7 spring");
    settime('h26, 'h04, 'h05, 'h02, 'h01, 'h59, 'h59); run(20, 1); readall("R7 not sunday");
    settime('h26, 'h10, 'h27, 'h01, 'h01, 'h59, 'h59); run(20, 1); readall("R8 autumn repeat");
    ref_mode = 0; wr(1, 'h59); wr(0, 'h59); run(20, 1); readall("R8 autumn second pass");

    // R9 alarm with don't-care fields, gapped reference
    wr(11, 'h22); rd(12, "R13 pre-clear");
    wr(7, 'h05); wr(8, 'hC0); wr(9, 'hFF);
    settime('h26, 'h05, 'h10, 'h03, 'h10, 'h20, 'h03);
    run(80, 2); rd(12, "R9 alarm seen"); rd(12, "R13 cleared");
    wr(9, 'h11);
    settime('h26, 'h05, 'h10, 'h03, 'h10, 'h20, 'h03);
    run(80, 2); rd(12, "R9 hour mismatch");

    // R10 periodic rates and R12 masking
    wr(11, 'h42); wr(10, 3); run(40, 1); rd(12, "R10 code 3");
    wr(10, 4); run(40, 2); rd(12, "R10 code 4");
    wr(10, 15); run(40, 1); rd(12, "R10 code 15");
    wr(10, 2); rd(12, "R13 clear"); run(40, 1); rd(12, "R10 code 2 off");
    wr(10, 3); wr(11, 'h02); run(30, 1); rd(12, "R12 masked");

    // R11 update flag
    wr(10, 0); wr(11, 'h12); rd(12, "R13 clear"); run(40, 2); rd(12, "R11 update");
    rd(12, "R13 second read");
    done = 1;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule